// File: doc/BRIEF.md
# Bit, Shift and Rotate Execution Unit

This unit executes the prefixed bit-manipulation instructions of a small 8-bit processor, plus its four unprefixed accumulator rotates. The decoder hands it an 8-bit prefixed opcode, the current flags and, for a register target, the register's value. The unit returns the new value, the new flags, a register write-back strobe and the index of the register to write.

When the opcode names the memory operand, a small sequencer runs a read, a modify step and a write. The address comes from outside the block; the block only raises its read and write strobes. A bit test reads but never writes. A new operation is accepted only while the unit is idle.

Top module: `bsr_unit`

## Requirements
- R1: Opcode bits 7:6 pick the group (0 shift/rotate, 1 bit test, 2 bit clear, 3 bit set), bits 5:3 pick the shift kind or bit index, bits 2:0 pick the target (0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 6 memory, 7 A); `tgt_idx` reports the target while `done` is high.
- R2: Rotate kinds: 0 rotates left with bit 7 into both bit 0 and carry; 1 rotates right with bit 0 into both bit 7 and carry; 2 rotates left through carry (carry into bit 0, bit 7 into carry); 3 rotates right through carry (carry into bit 7, bit 0 into carry).
- R3: Shift kinds: 4 shifts left filling zero with bit 7 into carry; 5 shifts right keeping bit 7 with bit 0 into carry; 6 exchanges the nibbles and clears carry; 7 shifts right filling zero with bit 0 into carry.
- R4: Flags are packed as bit 3 zero, bit 2 subtract, bit 1 half-carry, bit 0 carry. Every prefixed shift/rotate/swap clears subtract and half-carry and sets zero exactly when the result is 0.
- R5: Bit test sets zero when the selected bit is 0, clears subtract, sets half-carry, keeps carry, returns the operand unchanged and writes nothing back (no `reg_we`, no memory write).
- R6: Bit clear and bit set change only the selected bit (mask 1 shifted left by the index) and leave all flags as they were.
- R7: With `acc_rot` high, bits 4:3 of the opcode (kinds 0 to 3) give the same movement as the prefixed rotate, the target is A (index 7), and zero, subtract and half-carry are all cleared.
- R8: A register-target operation raises `done` for one cycle, one cycle after the accepting edge, with `reg_we` high unless it is a bit test; memory strobes stay low.
- R9: A memory-target operation raises `mem_rd` for one cycle, then (except bit test) `mem_wr` for one cycle with `mem_wdata` equal to the result, then `done`; `reg_we` stays low.
- R10: `start` while the unit is busy is ignored; the running operation completes with its own opcode and operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Issue an operation (accepted when idle) |
| acc_rot | input | 1 | Treat opcode as unprefixed accumulator rotate |
| opcode | input | 8 | Prefixed opcode (group, kind/index, target) |
| reg_val | input | W | Register operand value |
| flags_in | input | 4 | Current flags {Z,N,H,C} |
| mem_rdata | input | W | Byte read from memory while `mem_rd` is high |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | W | Byte to write while `mem_wr` is high |
| result | output | W | New value, valid with `done` |
| flags_out | output | 4 | New flags {Z,N,H,C}, valid with `done` |
| reg_we | output | 1 | Register write-back strobe |
| tgt_idx | output | 3 | Target register index |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation complete (one-cycle pulse) |

## Verification
All 256 prefixed opcodes are swept with operands 00, 80, 01, A5, FF and 3C under incoming flags with carry clear and with every flag set. The zero, one-hot-high and one-hot-low operands separate the circular rotates from the through-carry ones and from the logical and arithmetic right shifts, while FF and 00 expose zero-flag and bit-test polarity errors. The two flag settings show whether carry and the other flags are kept or cleared. The accumulator rotates and a start issued mid-operation are tried separately, along with the cycle count and strobe count of each memory sequence.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
   typedef enum logic [1:0] {
      GRP_SHIFT = 2'd0,
      GRP_TEST  = 2'd1,
      GRP_CLR   = 2'd2,
      GRP_SET   = 2'd3
   } grp_e;

   typedef enum logic [2:0] {
      SH_ROL_CIRC = 3'd0,
      SH_ROR_CIRC = 3'd1,
      SH_ROL_CARRY = 3'd2,
      SH_ROR_CARRY = 3'd3,
      SH_SHL       = 3'd4,
      SH_SHR_ARITH = 3'd5,
      SH_NIBSWAP   = 3'd6,
      SH_SHR_LOGIC = 3'd7
   } shk_e;

   typedef struct packed {
      logic z;
      logic n;
      logic h;
      logic c;
   } flags_t;

   localparam logic [2:0] TGT_MEM = 3'd6;
   localparam logic [2:0] TGT_ACC = 3'd7;
endpackage

// File: rtl/bsr_shift_core.sv
module bsr_shift_core
   import bsr_pkg::*;
#(
   parameter int W = 8
) (
   input  shk_e         kind,
   input  logic [W-1:0] din,
   input  logic         cin,
   output logic [W-1:0] dout,
   output logic         cout
);
   localparam int HALF = W / 2;

   always_comb begin
      dout = din;
      cout = 1'b0;
      unique case (kind)
         SH_ROL_CIRC:  begin dout = {din[W-2:0], din[W-1]};    cout = din[W-1]; end
         SH_ROR_CIRC:  begin dout = {din[0], din[W-1:1]};      cout = din[0];   end
         SH_ROL_CARRY: begin dout = {din[W-2:0], cin};         cout = din[W-1]; end
         SH_ROR_CARRY: begin dout = {cin, din[W-1:1]};         cout = din[0];   end
         SH_SHL:       begin dout = {din[W-2:0], 1'b0};        cout = din[W-1]; end
         SH_SHR_ARITH: begin dout = {din[W-1], din[W-1:1]};    cout = din[0];   end
         SH_NIBSWAP:   begin dout = {din[HALF-1:0], din[W-1:HALF]}; cout = 1'b0; end
         SH_SHR_LOGIC: begin dout = {1'b0, din[W-1:1]};        cout = din[0];   end
         default:      begin dout = din;                       cout = 1'b0;     end
      endcase
   end
endmodule

// File: rtl/bsr_bitop_core.sv
module bsr_bitop_core
   import bsr_pkg::*;
#(
   parameter int W     = 8,
   parameter int IDX_W = 3
) (
   input  grp_e             grp,
   input  logic [IDX_W-1:0] idx,
   input  logic [W-1:0]     din,
   output logic [W-1:0]     dout,
   output logic             sel_zero
);
   localparam int NSEL = 1 << IDX_W;
   logic [W-1:0] mask;

   for (genvar g = 0; g < W; g++) begin : g_mask
      if (g < NSEL) begin : g_live
         assign mask[g] = (idx == IDX_W'(g));
      end else begin : g_dead
         assign mask[g] = 1'b0;
      end
   end

   always_comb begin
      unique case (grp)
         GRP_CLR: dout = din & ~mask;
         GRP_SET: dout = din | mask;
         default: dout = din;
      endcase
   end

   assign sel_zero = ~|(din & mask);
endmodule

// File: rtl/bsr_rmw_ctrl.sv
module bsr_rmw_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic start_mem,
   input  logic test_q,
   output logic accept,
   output logic cap_mem,
   output logic mem_rd,
   output logic mem_wr,
   output logic busy,
   output logic done
);
   typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_STORE, ST_FIN} st_e;
   st_e st_q, st_d;

   assign accept = start && (st_q == ST_IDLE);

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:  if (accept) st_d = start_mem ? ST_LOAD : ST_FIN;
         ST_LOAD:  st_d = test_q ? ST_FIN : ST_STORE;
         ST_STORE: st_d = ST_FIN;
         ST_FIN:   st_d = ST_IDLE;
         default:  st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   assign cap_mem = (st_q == ST_LOAD);
   assign mem_rd  = (st_q == ST_LOAD);
   assign mem_wr  = (st_q == ST_STORE);
   assign busy    = (st_q != ST_IDLE);
   assign done    = (st_q == ST_FIN);

   assert_rd_wr_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));
   assert_wr_after_rd_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> $past(mem_rd));
   assert_test_no_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && test_q) |=> !mem_wr);
   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_no_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> !(mem_rd && $past(done)));
endmodule

// File: rtl/bsr_unit.sv
module bsr_unit
   import bsr_pkg::*;
#(
   parameter int W     = 8,
   parameter int OP_W  = 8,
   parameter int IDX_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            acc_rot,
   input  logic [OP_W-1:0] opcode,
   input  logic [W-1:0]    reg_val,
   input  logic [3:0]      flags_in,
   input  logic [W-1:0]    mem_rdata,
   output logic            mem_rd,
   output logic            mem_wr,
   output logic [W-1:0]    mem_wdata,
   output logic [W-1:0]    result,
   output logic [3:0]      flags_out,
   output logic            reg_we,
   output logic [2:0]      tgt_idx,
   output logic            busy,
   output logic            done
);
   localparam int TGT_LSB = 0;
   localparam int SEL_LSB = TGT_LSB + 3;
   localparam int GRP_LSB = SEL_LSB + IDX_W;

   if (W < 8 || (W % 2) != 0) begin : g_bad_w
      $error("bsr_unit: W must be even and at least 8");
   end
   if (OP_W != GRP_LSB + 2) begin : g_bad_op
      $error("bsr_unit: OP_W must equal 5 + IDX_W");
   end

   grp_e             grp_in;
   logic [2:0]       tgt_in;
   logic             accept, cap_mem;

   grp_e             grp_q;
   logic [IDX_W-1:0] sel_q;
   logic [2:0]       tgt_q;
   logic             acc_q;
   flags_t           fl_q;
   logic [W-1:0]     opnd_q;

   assign grp_in = acc_rot ? GRP_SHIFT : grp_e'(opcode[GRP_LSB +: 2]);
   assign tgt_in = acc_rot ? TGT_ACC : opcode[TGT_LSB +: 3];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grp_q  <= GRP_SHIFT;
         sel_q  <= '0;
         tgt_q  <= '0;
         acc_q  <= 1'b0;
         fl_q   <= '0;
         opnd_q <= '0;
      end else if (accept) begin
         grp_q  <= grp_in;
         sel_q  <= acc_rot ? {1'b0, opcode[SEL_LSB +: IDX_W-1]} : opcode[SEL_LSB +: IDX_W];
         tgt_q  <= tgt_in;
         acc_q  <= acc_rot;
         fl_q   <= flags_t'(flags_in);
         opnd_q <= reg_val;
      end else if (cap_mem) begin
         opnd_q <= mem_rdata;
      end
   end

   bsr_rmw_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .start_mem (tgt_in == TGT_MEM),
      .test_q    (grp_q == GRP_TEST),
      .accept    (accept),
      .cap_mem   (cap_mem),
      .mem_rd    (mem_rd),
      .mem_wr    (mem_wr),
      .busy      (busy),
      .done      (done)
   );

   logic [W-1:0] sh_out, bo_out;
   logic         sh_c, sel_zero;

   bsr_shift_core #(.W(W)) u_shift (
      .kind (shk_e'(sel_q[2:0])),
      .din  (opnd_q),
      .cin  (fl_q.c),
      .dout (sh_out),
      .cout (sh_c)
   );

   bsr_bitop_core #(.W(W), .IDX_W(IDX_W)) u_bitop (
      .grp      (grp_q),
      .idx      (sel_q),
      .din      (opnd_q),
      .dout     (bo_out),
      .sel_zero (sel_zero)
   );

   flags_t fl_new;
   always_comb begin
      fl_new = fl_q;
      unique case (grp_q)
         GRP_SHIFT: begin
            fl_new.z = acc_q ? 1'b0 : (sh_out == '0);
            fl_new.n = 1'b0;
            fl_new.h = 1'b0;
            fl_new.c = sh_c;
         end
         GRP_TEST: begin
            fl_new.z = sel_zero;
            fl_new.n = 1'b0;
            fl_new.h = 1'b1;
         end
         default: fl_new = fl_q;
      endcase
   end

   assign result    = (grp_q == GRP_SHIFT) ? sh_out : bo_out;
   assign flags_out = fl_new;
   assign mem_wdata = result;
   assign tgt_idx   = tgt_q;
   assign reg_we    = done && (tgt_q != TGT_MEM) && (grp_q != GRP_TEST);

   assert_we_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> done);
   assert_no_we_mem_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr) |-> !reg_we);
endmodule

// File: tb/bsr_unit_tb_top.sv
module bsr_unit_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       acc_rot = 1'b0;
   logic [7:0] opcode = '0;
   logic [7:0] reg_val = '0;
   logic [3:0] flags_in = '0;
   logic [7:0] mem_rdata = '0;
   logic       mem_rd, mem_wr, reg_we, busy, done;
   logic [7:0] mem_wdata, result;
   logic [3:0] flags_out;
   logic [2:0] tgt_idx;

   int total = 0;
   int bad = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   bsr_unit dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .acc_rot(acc_rot),
      .opcode(opcode), .reg_val(reg_val), .flags_in(flags_in),
      .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_wdata(mem_wdata), .result(result), .flags_out(flags_out),
      .reg_we(reg_we), .tgt_idx(tgt_idx), .busy(busy), .done(done)
   );

   task automatic check(input logic ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // returns {result[7:0], z, n, h, c}
   function automatic logic [11:0] ref_calc(input logic [7:0] op, input logic acc,
                                            input logic [7:0] v, input logic [3:0] f);
      int g, k, ci, r, c, z, n, h;
      g = acc ? 0 : int'(op[7:6]);
      k = acc ? int'(op[4:3]) : int'(op[5:3]);
      ci = int'(f[0]);
      r = v; c = ci; z = f[3]; n = f[2]; h = f[1];
      if (g == 0) begin
         case (k)
            0: begin r = (v * 2 + v / 128) % 256; c = v / 128; end
            1: begin r = v / 2 + (v % 2) * 128;   c = v % 2;   end
            2: begin r = (v * 2 + ci) % 256;      c = v / 128; end
            3: begin r = v / 2 + ci * 128;        c = v % 2;   end
            4: begin r = (v * 2) % 256;           c = v / 128; end
            5: begin r = v / 2 + (v / 128) * 128; c = v % 2;   end
            6: begin r = (v % 16) * 16 + v / 16;  c = 0;       end
            default: begin r = v / 2;             c = v % 2;   end
         endcase
         z = acc ? 0 : (r == 0);
         n = 0; h = 0;
      end else if (g == 1) begin
         z = ((v >> k) % 2) == 0;
         n = 0; h = 1;
      end else if (g == 2) begin
         r = v - (((v >> k) % 2) << k);
      end else begin
         r = v | (1 << k);
      end
      return {r[7:0], z[0], n[0], h[0], c[0]};
   endfunction

   task automatic run_op(input logic [7:0] op, input logic acc,
                         input logic [7:0] v, input logic [3:0] f);
      logic [11:0] e;
      int cyc, rds, wrs, g, exp_cyc;
      logic [7:0] wd;
      logic is_mem;
      e = ref_calc(op, acc, v, f);
      g = acc ? 0 : int'(op[7:6]);
      is_mem = !acc && (op[2:0] == 3'd6);
      exp_cyc = is_mem ? ((g == 1) ? 2 : 3) : 1;
      @(negedge clk);
      opcode = op; acc_rot = acc; reg_val = is_mem ? ~v : v;
      mem_rdata = v; flags_in = f; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 1; rds = 0; wrs = 0; wd = '0;
      while (!done && cyc < 8) begin
         if (mem_rd) rds++;
         if (mem_wr) begin wrs++; wd = mem_wdata; end
         @(negedge clk);
         cyc++;
      end
      if (g == 0 && acc)
         check(result == e[11:4] && flags_out == e[3:0], "R7", {result, flags_out}, e);
      else if (g == 0 && int'(op[5:3]) < 4)
         check(result == e[11:4] && flags_out == e[3:0], "R2/R4", {result, flags_out}, e);
      else if (g == 0)
         check(result == e[11:4] && flags_out == e[3:0], "R3/R4", {result, flags_out}, e);
      else if (g == 1)
         check(result == v && flags_out == e[3:0], "R5", {result, flags_out}, {v, e[3:0]});
      else
         check(result == e[11:4] && flags_out == f, "R6", {result, flags_out}, e);
      check(tgt_idx == (acc ? 3'd7 : op[2:0]), "R1", tgt_idx, acc ? 7 : op[2:0]);
      check(cyc == exp_cyc, is_mem ? "R9" : "R8", cyc, exp_cyc);
      check(reg_we == (!is_mem && g != 1), (g == 1) ? "R5" : "R8", reg_we, !is_mem && g != 1);
      check(rds == (is_mem ? 1 : 0), "R9", rds, is_mem);
      check(wrs == ((is_mem && g != 1) ? 1 : 0), (g == 1) ? "R5" : "R9", wrs, is_mem && g != 1);
      if (wrs == 1) check(wd == e[11:4], "R9", wd, e[11:4]);
   endtask

   initial begin
      while (cycles < 150000) begin
         @(posedge clk);
         cycles++;
      end
      check(1'b0, "watchdog", cycles, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] vals [6];
      logic [3:0] fls [2];
      vals = '{8'h00, 8'h80, 8'h01, 8'hA5, 8'hFF, 8'h3C};
      fls  = '{4'h0, 4'hF};
      repeat (3) @(negedge clk);
      check(!done && !busy && !mem_rd && !mem_wr && !reg_we, "R8 reset",
            {done, busy, mem_rd, mem_wr, reg_we}, 0);
      rst_n = 1'b1;
      for (int op = 0; op < 256; op++)
         for (int vi = 0; vi < 6; vi++)
            for (int fi = 0; fi < 2; fi++)
               run_op(8'(op), 1'b0, vals[vi], fls[fi]);
      // R7: accumulator rotates, kinds 0..3 in bits 4:3
      for (int k = 0; k < 4; k++)
         for (int vi = 0; vi < 6; vi++)
            for (int fi = 0; fi < 2; fi++)
               run_op(8'(k << 3), 1'b1, vals[vi], fls[fi]);
      // R10: second start during a memory set-bit-0 is ignored
      @(negedge clk);
      opcode = 8'hC6; acc_rot = 1'b0; mem_rdata = 8'h00; flags_in = 4'h0; start = 1'b1;
      @(negedge clk);
      opcode = 8'h86; mem_rdata = 8'h00;
      @(negedge clk);
      start = 1'b0;
      check(mem_wr && mem_wdata == 8'h01, "R10", {mem_wr, mem_wdata}, 9'h101);
      @(negedge clk);
      check(done && result == 8'h01, "R10", {done, result}, 9'h101);
      @(negedge clk);
      check(!busy && !mem_rd, "R10", {busy, mem_rd}, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule